// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

The block is a first-in first-out buffer for 9-bit words. It has a power-of-two depth and separate write and read clocks. A word is stored on a write-clock rising edge when the write is qualified. On a read-clock rising edge with both read enables low, a word moves from the storage array into an output register. The output register drives the data bus through a tri-state control. Four active-low status flags are provided. Empty and almost-empty are registered on the read clock. Full and almost-full are registered on the write clock. The almost thresholds come from two offset inputs, which an external offset block supplies and which hold 7 after reset.

A dual-purpose write pin, `wr_en2_ld`, is sampled on write-clock edges while reset is low, and its role is fixed from then on. If it is high during reset, it becomes a second write enable. If it is low during reset, the block enters offset-load mode and the pin selects between the FIFO and the external offset block. In that mode the block raises a write strobe or a read strobe toward the offset block instead of touching the FIFO. Each pointer crosses into the other clock domain as a Gray code through two flip-flops. A pointer move therefore reaches the opposite side's flags on the third edge of that side's clock.

Top module: `fifo_dc_pflag`

## Requirements
- R1: While `rst_n` is low, both pointers are zero, `full_n` and `almost_full_n` are 1, `empty_n` and `almost_empty_n` are 0, the output register is 0, and both offset strobes are 0.
- R2: If `wr_en2_ld` is 1 during reset (two-enable mode), a word is stored only when `wr_en1_n` is 0 and `wr_en2_ld` is 1. In this mode, `ofs_wr` stays 0 for every input combination.
- R3: If `wr_en2_ld` is 0 during reset (offset-load mode), `ofs_wr` is 1 exactly while `wr_en1_n` and `wr_en2_ld` are both 0, and the FIFO stores nothing. With `wr_en2_ld` at 1 and `wr_en1_n` at 0, a word is stored as usual.
- R4: A FIFO read happens on a `rd_clk` rising edge only when `rd_en1_n` and `rd_en2_n` are both 0. Otherwise the output register keeps its value.
- R5: In offset-load mode, with `wr_en2_ld` at 0 and both read enables low, `ofs_rd` is 1. The output register then loads `ofs_rdata` and the read pointer does not move, even if the FIFO is empty.
- R6: A write attempt while `full_n` is 0 stores nothing. A read attempt while `empty_n` is 0 leaves the read pointer and the output register unchanged.
- R7: For word count c and depth D, `empty_n` is 0 exactly when c is 0, and `full_n` is 0 exactly when c equals D, each as seen by its own clock domain.
- R8: With n on `ae_ofs` and m on `af_ofs`, `almost_empty_n` is 0 when c is at most n, and `almost_full_n` is 0 when c is at least D−m.
- R9: A flag registered on the clock that moved its own pointer updates on that same edge. A movement of the other domain's pointer reaches the flag on the third rising edge of the flag's clock after the moving edge.
- R10: When `oe_n` is 1, `dout` is high impedance. When `oe_n` is 0, `dout` carries the output register.
- R11: Words leave the FIFO in the order they were stored, with no loss or duplication across full and empty wrap-arounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset; also the window in which the mode is sampled |
| din | input | 9 | Write data |
| wr_en1_n | input | 1 | Primary write enable, active low |
| wr_en2_ld | input | 1 | Second write enable (active high) or offset-load select (low selects offsets) |
| rd_en1_n | input | 1 | Read enable one, active low |
| rd_en2_n | input | 1 | Read enable two, active low |
| oe_n | input | 1 | Output drive enable, active low |
| ae_ofs | input | 6 | Almost-empty offset n from the offset block |
| af_ofs | input | 6 | Almost-full offset m from the offset block |
| ofs_rdata | input | 9 | Read data from the offset block |
| ofs_wr | output | 1 | Write strobe to the offset block |
| ofs_rd | output | 1 | Read strobe to the offset block |
| dout | output | 9 | Read data bus, tri-stated by `oe_n` |
| empty_n | output | 1 | Empty flag, active low, read domain |
| almost_empty_n | output | 1 | Almost-empty flag, active low, read domain |
| almost_full_n | output | 1 | Almost-full flag, active low, write domain |
| full_n | output | 1 | Full flag, active low, write domain |

## Verification
The bench drives both clocks from one source, which makes every latency an exact edge count. The output register and the own-side flag effects are due right after the edge that accepts the operation. A movement of the opposite pointer shows up on the flags three edges later. The offset strobes follow the inputs combinationally. The reference model keeps cumulative write and read totals with a three-entry history of each, so each flag is computed from this edge's own total and the other total from three edges earlier. Every output is compared half a period after each rising edge, with the inputs still stable.

// File: rtl/fifo_dc_pflag.sv
module fifo_dc_pflag #(
  parameter int DEPTH = 64,
  parameter int W     = 9
) (
  input  logic                       wr_clk,
  input  logic                       rd_clk,
  input  logic                       rst_n,
  input  logic [W-1:0]               din,
  input  logic                       wr_en1_n,
  input  logic                       wr_en2_ld,
  input  logic                       rd_en1_n,
  input  logic                       rd_en2_n,
  input  logic                       oe_n,
  input  logic [$clog2(DEPTH)-1:0]   ae_ofs,
  input  logic [$clog2(DEPTH)-1:0]   af_ofs,
  input  logic [W-1:0]               ofs_rdata,
  output logic                       ofs_wr,
  output logic                       ofs_rd,
  output logic [W-1:0]               dout,
  output logic                       empty_n,
  output logic                       almost_empty_n,
  output logic                       almost_full_n,
  output logic                       full_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEP = PW'(DEPTH);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [W-1:0]  mem [DEPTH];
  logic          ld_mode;
  logic [PW-1:0] wbin, wgray, rg_s1, rg_s2, wbin_nx, wcnt_nx;
  logic [PW-1:0] rbin, rgray, wg_s1, wg_s2, rbin_nx, rcnt_nx;
  logic [W-1:0]  q_reg;
  logic          wr_fifo, rd_req, rd_fifo;

  // role of the dual-purpose pin, captured while reset is held
  always_ff @(posedge wr_clk)
    if (!rst_n) ld_mode <= ~wr_en2_ld;

  // ---------------- write domain ----------------
  assign wr_fifo = rst_n & ~wr_en1_n & wr_en2_ld & full_n;
  assign ofs_wr  = rst_n & ld_mode & ~wr_en1_n & ~wr_en2_ld;
  assign wbin_nx = wbin + PW'(wr_fifo);
  assign wcnt_nx = wbin_nx - g2b(rg_s2);

  always_ff @(posedge wr_clk or negedge rst_n)
    if (!rst_n) begin
      wbin <= '0; wgray <= '0; rg_s1 <= '0; rg_s2 <= '0;
      full_n <= 1'b1; almost_full_n <= 1'b1;
    end else begin
      wbin  <= wbin_nx;
      wgray <= wbin_nx ^ (wbin_nx >> 1);
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      full_n        <= (wcnt_nx != DEP);
      almost_full_n <= (wcnt_nx < (DEP - {1'b0, af_ofs}));
    end

  always_ff @(posedge wr_clk)
    if (wr_fifo) mem[wbin[AW-1:0]] <= din;

  // ---------------- read domain ----------------
  assign rd_req  = ~rd_en1_n & ~rd_en2_n;
  assign ofs_rd  = rst_n & ld_mode & ~wr_en2_ld & rd_req;
  assign rd_fifo = rd_req & empty_n & ~ofs_rd;
  assign rbin_nx = rbin + PW'(rd_fifo);
  assign rcnt_nx = g2b(wg_s2) - rbin_nx;

  always_ff @(posedge rd_clk or negedge rst_n)
    if (!rst_n) begin
      rbin <= '0; rgray <= '0; wg_s1 <= '0; wg_s2 <= '0;
      q_reg <= '0; empty_n <= 1'b0; almost_empty_n <= 1'b0;
    end else begin
      rbin  <= rbin_nx;
      rgray <= rbin_nx ^ (rbin_nx >> 1);
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      empty_n        <= (rcnt_nx != '0);
      almost_empty_n <= (rcnt_nx > {1'b0, ae_ofs});
      if (ofs_rd)       q_reg <= ofs_rdata;
      else if (rd_fifo) q_reg <= mem[rbin[AW-1:0]];
    end

  assign dout = oe_n ? {W{1'bz}} : q_reg;

  // ---------------- assertions ----------------
  p_no_overflow_r6: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (!full_n && !wr_en1_n && wr_en2_ld) |=> $stable(wbin));
  p_no_underflow_r6: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!empty_n && rd_req) |=> ($stable(rbin) && $stable(rgray)));
  p_hold_r4: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !rd_req |=> $stable(q_reg));
  p_ofs_read_keeps_ptr_r5: assert property (@(posedge rd_clk) disable iff (!rst_n)
    ofs_rd |=> $stable(rbin));
  p_ofs_write_no_store_r3: assert property (@(posedge wr_clk) disable iff (!rst_n)
    ofs_wr |=> $stable(wbin));
  p_full_implies_af_r8: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |-> !almost_full_n);
  p_empty_implies_ae_r8: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n |-> !almost_empty_n);
  p_strobes_exclusive_r3: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $onehot0({ofs_wr, wr_fifo}));
endmodule

// File: tb/fifo_dc_pflag_tb.sv
module fifo_dc_pflag_tb;
  localparam int D = 64;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, wen1_n, pin, ren1_n, ren2_n, oe_n;
  logic [8:0] din, ofs_data, dout;
  logic [5:0] n_ofs, m_ofs;
  logic ofs_wr, ofs_rd, empty_n, ae_n, af_n, full_n;

  fifo_dc_pflag u_dut (
    .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .din(din),
    .wr_en1_n(wen1_n), .wr_en2_ld(pin), .rd_en1_n(ren1_n), .rd_en2_n(ren2_n),
    .oe_n(oe_n), .ae_ofs(n_ofs), .af_ofs(m_ofs), .ofs_rdata(ofs_data),
    .ofs_wr(ofs_wr), .ofs_rd(ofs_rd), .dout(dout), .empty_n(empty_n),
    .almost_empty_n(ae_n), .almost_full_n(af_n), .full_n(full_n));

  int vectors = 0, fails = 0;
  bit done = 0;
  string ph = "R1";

  // reference model state
  logic [8:0] q_m[$];
  logic [8:0] m_q;
  bit m_mode_ld, m_full_n, m_af_n, m_empty_n, m_ae_n;
  int wtot, rtot;
  int wh[4], rh[4];

  task automatic chk(string nm, logic [8:0] act, logic [8:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", ph, nm, act, exp);
    end
  endtask

  task automatic compare();
    bit exp_ow, exp_or;
    exp_ow = rst_n && m_mode_ld && !wen1_n && !pin;
    exp_or = rst_n && m_mode_ld && !pin && !ren1_n && !ren2_n;
    chk("R7 empty_n", 9'(empty_n), 9'(m_empty_n));
    chk("R7 full_n", 9'(full_n), 9'(m_full_n));
    chk("R8 almost_empty_n", 9'(ae_n), 9'(m_ae_n));
    chk("R8 almost_full_n", 9'(af_n), 9'(m_af_n));
    chk("R3 ofs_wr", 9'(ofs_wr), 9'(exp_ow));
    chk("R5 ofs_rd", 9'(ofs_rd), 9'(exp_or));
    if (oe_n) chk("R10 dout hiz", dout, 9'bz);
    else      chk("R11 dout", dout, m_q);
  endtask

  task automatic model_edge();
    bit wacc, racc, oacc;
    int cw, cr;
    wacc = !wen1_n && pin && m_full_n;
    oacc = m_mode_ld && !pin && !ren1_n && !ren2_n;
    racc = !ren1_n && !ren2_n && m_empty_n && !oacc;
    if (wacc) q_m.push_back(din);
    if (oacc) m_q = ofs_data;
    else if (racc) m_q = q_m.pop_front();
    wtot += int'(wacc);
    rtot += int'(racc);
    for (int k = 3; k > 0; k--) begin wh[k] = wh[k-1]; rh[k] = rh[k-1]; end
    wh[0] = wtot; rh[0] = rtot;
    cw = wtot - rh[3];
    cr = wh[3] - rtot;
    m_full_n  = (cw != D);
    m_af_n    = (cw < D - int'(m_ofs));
    m_empty_n = (cr != 0);
    m_ae_n    = (cr > int'(n_ofs));
  endtask

  task automatic step(bit w1, bit p, logic [8:0] d, bit r1, bit r2);
    wen1_n = w1; pin = p; din = d; ren1_n = r1; ren2_n = r2;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) step(1'b1, 1'b1, 9'h0, 1'b1, 1'b1);
  endtask

  task automatic do_reset(bit level);
    ph = "R1";
    rst_n = 1'b0; pin = level; wen1_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
    n_ofs = 6'd7; m_ofs = 6'd7;
    q_m.delete();
    m_q = '0; wtot = 0; rtot = 0;
    for (int k = 0; k < 4; k++) begin wh[k] = 0; rh[k] = 0; end
    m_full_n = 1; m_af_n = 1; m_empty_n = 0; m_ae_n = 0;
    m_mode_ld = !level;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      compare();
    end
    rst_n = 1'b1;
  endtask

  initial begin
    #1ms;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    oe_n = 1'b0; din = '0; ofs_data = 9'h0A5;
    do_reset(1'b1);

    ph = "R2";
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 9'(i*37+5), 1'b1, 1'b1);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 9'h1FF, 1'b1, 1'b1);
    for (int i = 0; i < 2; i++) step(1'b1, 1'b1, 9'h155, 1'b1, 1'b1);
    ph = "R9";
    idle(4);

    ph = "R4";
    for (int i = 0; i < 2; i++) step(1'b1, 1'b1, 9'h0, 1'b0, 1'b1);
    for (int i = 0; i < 2; i++) step(1'b1, 1'b1, 9'h0, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 9'h0, 1'b0, 1'b0);
    idle(2);

    ph = "R6";
    for (int i = 0; i < 70; i++) step(1'b0, 1'b1, 9'(i*11+3), 1'b1, 1'b1);
    idle(4);
    ph = "R8";
    m_ofs = 6'd3;
    idle(2);
    for (int i = 0; i < 6; i++) begin step(1'b1, 1'b1, 9'h0, 1'b0, 1'b0); idle(3); end
    ph = "R6";
    for (int i = 0; i < 70; i++) step(1'b1, 1'b1, 9'h0, 1'b0, 1'b0);
    idle(4);

    ph = "R8";
    n_ofs = 6'd2;
    for (int i = 0; i < 4; i++) begin step(1'b0, 1'b1, 9'(100+i), 1'b1, 1'b1); idle(4); end
    ph = "R11";
    for (int i = 0; i < 30; i++)
      step(1'b0, 1'b1, 9'(i*53+17), (i % 3 == 2), 1'b0);
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 9'h0, 1'b0, 1'b0);
    idle(4);

    ph = "R10";
    step(1'b0, 1'b1, 9'h1C3, 1'b1, 1'b1);
    idle(4);
    oe_n = 1'b1;
    step(1'b1, 1'b1, 9'h0, 1'b0, 1'b0);
    idle(1);
    oe_n = 1'b0;
    idle(1);

    do_reset(1'b0);
    ph = "R3";
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 9'(i+1), 1'b1, 1'b1);
    idle(4);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 9'(200+i), 1'b1, 1'b1);
    idle(4);
    ph = "R5";
    step(1'b1, 1'b0, 9'h0, 1'b0, 1'b0);
    ofs_data = 9'h13C;
    step(1'b1, 1'b0, 9'h0, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 9'h0, 1'b0, 1'b0);
    idle(4);
    step(1'b1, 1'b0, 9'h0, 1'b0, 1'b0);
    idle(2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule